// File: doc/BRIEF.md
# Segmented Byte-Lane Bus Unit

This block turns a segmented memory request into the bus cycles that a 16-bit memory needs. A request carries a 16-bit offset, a byte or word size, a read or write flag and an access kind: instruction fetch, stack-relative or plain data. The access kind picks one of three segment values supplied by the surrounding core. The block forms a 20-bit byte address from that segment and the offset, then drives one or two transfers on a 16-bit data bus with two byte-enable lines.

Bytes are routed to the lane that matches the low address bit. A word at an even address moves in one transfer. A word at an odd address is split into two byte transfers on opposite lanes. Read data is collected into a right-justified result that appears with a one-cycle completion pulse. The memory side holds a transfer steady until the memory signals ready.

Top module: `seg_lane_bus`

## Requirements
- R1: The transfer address is (segment × 16 + offset) modulo 2^20. Segment 6020h with offset 4267h gives 64467h, and segment FFFFh with offset 0020h gives 00010h.
- R2: The access kind `cmd_kind` selects the segment: 2'b00 uses `seg_code`, 2'b01 uses `seg_stack`, and 2'b10 or 2'b11 uses `seg_data`.
- R3: A byte access to an even address uses `mem_be` = 2'b01 with the data on bits 7:0. A byte access to an odd address uses `mem_be` = 2'b10 with the data on bits 15:8. A byte read returns the byte in `rd_data[7:0]` with bits 15:8 zero.
- R4: A word access to an even address is one transfer with `mem_be` = 2'b11. The low byte is on bits 7:0, and the byte at the higher address is on bits 15:8.
- R5: A word access to an odd address is two transfers. The first is at the odd address with `mem_be` = 2'b10 and carries the word's low byte on bits 15:8. The second is at the next address with `mem_be` = 2'b01 and carries the high byte on bits 7:0. A read assembles both halves into `rd_data`.
- R6: The second transfer's offset is the first offset plus one, wrapped to 16 bits before the address is formed. Offset FFFFh therefore continues at offset 0000h of the same segment.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` hold their values on the next cycle.
- R8: `done` is high for exactly one cycle, in the cycle after the final transfer is acknowledged. `rd_data` holds the read result in that cycle.
- R9: `busy` is high from the cycle after a command is accepted through the `done` cycle. A command presented while `busy` is high is ignored.
- R10: While reset is high and after reset, `mem_req`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; accepted when not busy |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_word | input | 1 | 1 = word, 0 = byte |
| cmd_kind | input | 2 | Access kind: 00 fetch, 01 stack, 10/11 data |
| cmd_offset | input | 16 | Offset within the segment |
| cmd_wdata | input | 16 | Write value, right-justified for bytes |
| seg_code | input | 16 | Code segment value |
| seg_stack | input | 16 | Stack segment value |
| seg_data | input | 16 | Data segment value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with done |
| mem_req | output | 1 | Transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 20 | Byte address of the transfer |
| mem_be | output | 2 | Byte enables, bit 0 = bits 7:0 |
| mem_wdata | output | 16 | Write data on the lanes |
| mem_ready | input | 1 | Memory accepts or returns the transfer |
| mem_rdata | input | 16 | Read data from memory |

## Verification
The assertions check the properties visible at the memory port on every cycle. A held request must stay stable until it is acknowledged. The byte enables must match the low address bit. An acknowledged odd-lane first beat can only be followed by a lower-lane beat. The completion pulse must follow an acknowledgement and must last one cycle. Address formation, the choice of segment, the 16-bit offset wrap and the assembled read value depend on the command fields. Only the bench's reference model can confirm these, and it does so across fetch, stack and data kinds, odd and even offsets, the top-of-segment offset and varied memory latency.

// File: rtl/seg_lane_pkg.sv
package seg_lane_pkg;

    localparam int OFS_W     = 16;
    localparam int SEG_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PA_W      = 20;
    localparam int DW        = 16;
    localparam int BYTE_W    = 8;
    localparam int LANES     = DW / BYTE_W;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_STACK = 2'b01,
        KIND_DATA  = 2'b10,
        KIND_DATA2 = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_SECOND,
        PH_FIN
    } phase_e;

    typedef struct packed {
        logic             we;
        logic             wide;
        logic [SEG_W-1:0] seg;
        logic [OFS_W-1:0] ofs;
        logic [DW-1:0]    wdata;
    } job_t;

    typedef struct packed {
        logic [PA_W-1:0]  addr;
        logic [LANES-1:0] be;
        logic [DW-1:0]    wdata;
    } beat_t;

    function automatic logic [PA_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [OFS_W-1:0] ofs);
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] disp;
        base = {seg, {SEG_SHIFT{1'b0}}};
        disp = {{(PA_W-OFS_W){1'b0}}, ofs};
        return base + disp;
    endfunction

    function automatic logic needs_split(input job_t j);
        return j.wide & j.ofs[0];
    endfunction

endpackage

// File: rtl/seg_lane_pick.sv
module seg_lane_pick
    import seg_lane_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic [SEG_W-1:0] seg_code,
    input  logic [SEG_W-1:0] seg_stack,
    input  logic [SEG_W-1:0] seg_data,
    output logic [SEG_W-1:0] seg_sel
);
    always_comb begin
        unique case (acc_kind_e'(kind))
            KIND_FETCH: seg_sel = seg_code;
            KIND_STACK: seg_sel = seg_stack;
            default:    seg_sel = seg_data;
        endcase
    end
endmodule

// File: rtl/seg_lane_beat.sv
module seg_lane_beat
    import seg_lane_pkg::*;
(
    input  seg_lane_pkg::job_t  job,
    input  logic                second,
    output seg_lane_pkg::beat_t beat
);
    logic [OFS_W-1:0] ofs_eff;
    logic [BYTE_W-1:0] lo_b;
    logic [BYTE_W-1:0] hi_b;

    assign lo_b    = job.wdata[BYTE_W-1:0];
    assign hi_b    = job.wdata[DW-1:BYTE_W];
    // the +1 stays inside the 16-bit offset, so it wraps within the segment
    assign ofs_eff = second ? job.ofs + OFS_W'(1) : job.ofs;

    always_comb begin
        beat.addr = phys_addr(job.seg, ofs_eff);
        if (second) begin
            beat.be    = 2'b01;
            beat.wdata = {{BYTE_W{1'b0}}, hi_b};
        end else if (job.wide && !job.ofs[0]) begin
            beat.be    = 2'b11;
            beat.wdata = job.wdata;
        end else begin
            beat.be    = job.ofs[0] ? 2'b10 : 2'b01;
            beat.wdata = {lo_b, lo_b};
        end
    end
endmodule

// File: rtl/seg_lane_merge.sv
module seg_lane_merge
    import seg_lane_pkg::*;
(
    input  seg_lane_pkg::job_t job,
    input  logic               second,
    input  logic [DW-1:0]      hold,
    input  logic [DW-1:0]      rdata,
    output logic [DW-1:0]      merged
);
    logic [BYTE_W-1:0] lane_lo;
    logic [BYTE_W-1:0] lane_hi;

    assign lane_lo = rdata[BYTE_W-1:0];
    assign lane_hi = rdata[DW-1:BYTE_W];

    always_comb begin
        if (second)
            merged = {lane_lo, hold[BYTE_W-1:0]};
        else if (job.wide && !job.ofs[0])
            merged = rdata;
        else if (job.wide)
            merged = {hold[DW-1:BYTE_W], lane_hi};
        else
            merged = {{BYTE_W{1'b0}}, job.ofs[0] ? lane_hi : lane_lo};
    end
endmodule

// File: rtl/seg_lane_bus.sv
module seg_lane_bus
    import seg_lane_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic             cmd_word,
    input  logic [1:0]       cmd_kind,
    input  logic [OFS_W-1:0] cmd_offset,
    input  logic [DW-1:0]    cmd_wdata,
    input  logic [SEG_W-1:0] seg_code,
    input  logic [SEG_W-1:0] seg_stack,
    input  logic [SEG_W-1:0] seg_data,
    output logic             busy,
    output logic             done,
    output logic [DW-1:0]    rd_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [LANES-1:0] mem_be,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ready,
    input  logic [DW-1:0]    mem_rdata
);
    phase_e           phase;
    job_t             job;
    logic [DW-1:0]    hold;
    logic [SEG_W-1:0] seg_sel;
    logic             second;
    beat_t            beat;
    logic [DW-1:0]    merged;

    seg_lane_pick i_pick (
        .kind      (cmd_kind),
        .seg_code  (seg_code),
        .seg_stack (seg_stack),
        .seg_data  (seg_data),
        .seg_sel   (seg_sel)
    );

    assign second = (phase == PH_SECOND);

    seg_lane_beat i_beat (
        .job    (job),
        .second (second),
        .beat   (beat)
    );

    seg_lane_merge i_merge (
        .job    (job),
        .second (second),
        .hold   (hold),
        .rdata  (mem_rdata),
        .merged (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            job   <= '0;
            hold  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (cmd_valid) begin
                    job.we    <= cmd_write;
                    job.wide  <= cmd_word;
                    job.seg   <= seg_sel;
                    job.ofs   <= cmd_offset;
                    job.wdata <= cmd_wdata;
                    phase     <= PH_FIRST;
                end
                PH_FIRST: if (mem_ready) begin
                    if (!job.we) hold <= merged;
                    phase <= needs_split(job) ? PH_SECOND : PH_FIN;
                end
                PH_SECOND: if (mem_ready) begin
                    if (!job.we) hold <= merged;
                    phase <= PH_FIN;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign mem_req   = (phase == PH_FIRST) || (phase == PH_SECOND);
    assign mem_we    = job.we;
    assign mem_addr  = beat.addr;
    assign mem_be    = beat.be;
    assign mem_wdata = beat.wdata;
    assign busy      = (phase != PH_IDLE);
    assign done      = (phase == PH_FIN);
    assign rd_data   = hold;

endmodule

// File: rtl/seg_lane_bus_chk.sv
module seg_lane_bus_chk
    import seg_lane_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic [LANES-1:0] mem_be,
    input logic [DW-1:0]    mem_wdata,
    input logic             mem_ready
);
    p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                                  && $stable(mem_we) && $stable(mem_wdata));

    p_odd_lane_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_addr[0] |-> mem_be == 2'b10);

    p_even_lane_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_addr[0] |-> mem_be[0]);

    p_split_order_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ready |=> !mem_req || (mem_be == 2'b01 && $past(mem_be) == 2'b10));

    p_done_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_req && mem_ready));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy && !mem_req);

    p_done_is_busy_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
endmodule

bind seg_lane_bus seg_lane_bus_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/test_seg_lane_bus.sv
module test_seg_lane_bus;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic        cmd_word = 1'b0;
    logic [1:0]  cmd_kind = 2'b00;
    logic [15:0] cmd_offset = '0;
    logic [15:0] cmd_wdata = '0;
    logic [15:0] seg_code = 16'h1000;
    logic [15:0] seg_stack = 16'h2000;
    logic [15:0] seg_data = 16'h6020;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] rd_data, mem_wdata;
    logic [19:0] mem_addr;
    logic [1:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic [15:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    seg_lane_bus i_seg_lane_bus (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_word(cmd_word), .cmd_kind(cmd_kind), .cmd_offset(cmd_offset),
        .cmd_wdata(cmd_wdata), .seg_code(seg_code), .seg_stack(seg_stack),
        .seg_data(seg_data), .busy(busy), .done(done), .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    int    rdly = 0;
    int    rcnt = 0;
    string cur_tag = "R10";

    logic [7:0] bmem [int];

    function automatic logic [7:0] peek(int a);
        if (bmem.exists(a)) return bmem[a];
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic int phys(logic [15:0] s, logic [15:0] o);
        return (int'(s) * 16 + int'(o)) % 1048576;
    endfunction

    typedef struct {
        int         addr;
        logic [1:0] be;
        logic [15:0] wd;
    } xfer_t;

    xfer_t       mq[$];
    int          mst = 0;
    logic        m_we = 1'b0;
    logic [15:0] m_rd = '0;

    // reference model: advances on the clock from the bench-driven inputs
    always @(posedge clk) begin
        if (rst) begin
            mst = 0;
            mq.delete();
        end else begin
            case (mst)
                0: if (cmd_valid) begin
                    logic [15:0] s;
                    int a0, a1;
                    xfer_t x;
                    s  = (cmd_kind == 2'b00) ? seg_code :
                         (cmd_kind == 2'b01) ? seg_stack : seg_data;
                    a0 = phys(s, cmd_offset);
                    a1 = phys(s, cmd_offset + 16'd1);
                    m_we = cmd_write;
                    if (!cmd_word) begin
                        x.addr = a0; x.be = cmd_offset[0] ? 2'b10 : 2'b01;
                        x.wd = {cmd_wdata[7:0], cmd_wdata[7:0]};
                        mq.push_back(x);
                        m_rd = {8'h00, peek(a0)};
                    end else if (!cmd_offset[0]) begin
                        x.addr = a0; x.be = 2'b11; x.wd = cmd_wdata;
                        mq.push_back(x);
                        m_rd = {peek(a0 + 1), peek(a0)};
                    end else begin
                        x.addr = a0; x.be = 2'b10; x.wd = {cmd_wdata[7:0], 8'h00};
                        mq.push_back(x);
                        x.addr = a1; x.be = 2'b01; x.wd = {8'h00, cmd_wdata[15:8]};
                        mq.push_back(x);
                        m_rd = {peek(a1), peek(a0)};
                    end
                    mst = 1;
                end
                1: if (mem_ready) begin
                    void'(mq.pop_front());
                    if (mq.size() == 0) mst = 2;
                end
                default: mst = 0;
            endcase
        end
    end

    task automatic miss(string what, int act, int exp);
        n_bad++;
        $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", cur_tag, what, act, exp, cyc);
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic [15:0] mask;
        n_vec++;
        if (busy !== (mst != 0)) miss("busy", busy, mst != 0);
        if (done !== (mst == 2)) miss("done", done, mst == 2);
        if (mem_req !== (mst == 1)) miss("mem_req", mem_req, mst == 1);
        if (mst == 1 && mem_req === 1'b1) begin
            mask = {{8{mq[0].be[1]}}, {8{mq[0].be[0]}}};
            if (mem_addr !== 20'(mq[0].addr)) miss("mem_addr", mem_addr, mq[0].addr);
            if (mem_be !== mq[0].be) miss("mem_be", mem_be, mq[0].be);
            if (mem_we !== m_we) miss("mem_we", mem_we, m_we);
            if (m_we && ((mem_wdata & mask) !== (mq[0].wd & mask)))
                miss("mem_wdata", mem_wdata & mask, mq[0].wd & mask);
        end
        if (mst == 2 && !m_we && rd_data !== m_rd) miss("rd_data", rd_data, m_rd);
    end

    // memory responder with programmable latency
    always @(negedge clk) begin
        int base;
        mem_ready <= 1'b0;
        if (!rst && mem_req === 1'b1 && !(mem_ready && rdly > 0)) begin
            if (rcnt >= rdly) begin
                rcnt = 0;
                base = int'(mem_addr) & ~1;
                if (mem_we) begin
                    if (mem_be[0]) bmem[base]     = mem_wdata[7:0];
                    if (mem_be[1]) bmem[base + 1] = mem_wdata[15:8];
                end
                mem_rdata <= {peek(base + 1), peek(base)};
                mem_ready <= 1'b1;
            end else begin
                rcnt++;
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
            finish_run();
        end
    end

    task automatic issue(string tag, logic we, logic wide, logic [1:0] kind,
                         logic [15:0] ofs, logic [15:0] wd, logic pester);
        @(negedge clk);
        cur_tag    = tag;
        cmd_valid  = 1'b1;
        cmd_write  = we;
        cmd_word   = wide;
        cmd_kind   = kind;
        cmd_offset = ofs;
        cmd_wdata  = wd;
        @(negedge clk);
        if (pester) begin
            cmd_offset = ofs ^ 16'h0F0F;
            cmd_write  = ~we;
            cmd_kind   = kind ^ 2'b01;
        end else begin
            cmd_valid = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        n_vec++;
        if (mem_req !== 1'b0 || done !== 1'b0 || busy !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: actual %b%b%b expected 000", mem_req, done, busy);
        end
        rst = 1'b0;
        @(negedge clk);

        // R1: 6020:4267 -> 64467 (odd byte, data kind)
        issue("R1", 1'b0, 1'b0, 2'b10, 16'h4267, 16'h0000, 1'b0);
        // R2: fetch, stack, and kind 11 as data
        issue("R2", 1'b0, 1'b1, 2'b00, 16'h0100, 16'h0000, 1'b0);
        issue("R2", 1'b1, 1'b1, 2'b01, 16'h0202, 16'hBEEF, 1'b0);
        issue("R2", 1'b0, 1'b1, 2'b01, 16'h0202, 16'h0000, 1'b0);
        issue("R2", 1'b0, 1'b0, 2'b11, 16'h0010, 16'h0000, 1'b0);
        // R3: byte lanes
        issue("R3", 1'b1, 1'b0, 2'b10, 16'h0040, 16'h0011, 1'b0);
        issue("R3", 1'b1, 1'b0, 2'b10, 16'h0041, 16'h0022, 1'b0);
        issue("R3", 1'b0, 1'b1, 2'b10, 16'h0040, 16'h0000, 1'b0);
        issue("R3", 1'b0, 1'b0, 2'b10, 16'h0041, 16'h0000, 1'b0);
        // R4: aligned word
        issue("R4", 1'b1, 1'b1, 2'b10, 16'h0080, 16'hA55A, 1'b0);
        issue("R4", 1'b0, 1'b1, 2'b10, 16'h0080, 16'h0000, 1'b0);
        // R5: odd word split, with latency
        rdly = 2;
        issue("R5", 1'b1, 1'b1, 2'b10, 16'h1235, 16'hC3D4, 1'b0);
        issue("R5", 1'b0, 1'b1, 2'b10, 16'h1235, 16'h0000, 1'b0);
        issue("R5", 1'b0, 1'b0, 2'b10, 16'h1236, 16'h0000, 1'b0);
        // R6: offset FFFF wraps inside the segment
        rdly = 0;
        seg_data = 16'h3000;
        issue("R6", 1'b1, 1'b1, 2'b10, 16'hFFFF, 16'h7788, 1'b0);
        issue("R6", 1'b0, 1'b1, 2'b10, 16'hFFFF, 16'h0000, 1'b0);
        issue("R6", 1'b0, 1'b0, 2'b10, 16'h0000, 16'h0000, 1'b0);
        // R1: 20-bit wrap of the physical address
        seg_data = 16'hFFFF;
        issue("R1", 1'b0, 1'b1, 2'b10, 16'h0020, 16'h0000, 1'b0);
        // R7: long stalls hold the request
        rdly = 4;
        seg_data = 16'h6020;
        issue("R7", 1'b1, 1'b1, 2'b10, 16'h0301, 16'h1357, 1'b0);
        issue("R7", 1'b0, 1'b1, 2'b10, 16'h0301, 16'h0000, 1'b0);
        // R8 / R9: command held active and changed while busy is ignored
        rdly = 1;
        issue("R9", 1'b0, 1'b1, 2'b01, 16'h0203, 16'h0000, 1'b1);
        issue("R8", 1'b0, 1'b0, 2'b00, 16'h0005, 16'h0000, 1'b0);
        repeat (3) @(negedge clk);
        n_vec++;
        if (mem_req !== 1'b0 || busy !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 idle: actual %b%b expected 00", mem_req, busy);
        end
        finish_run();
    end

endmodule